// File: doc/BRIEF.md
# Bus Snoop Inquire Strobe Qualifier

This block lives in the bus interface of a processor. It runs on every clock and decides whether the external inquire strobe is a valid cache inquire (snoop) request. System logic can take the bus from the processor in three ways: an address-hold request, a back-off request, or a bus-hold request that the processor grants with hold-acknowledge. Each of these opens a sampling window after its own delay. The strobe counts only inside an open window. Some conditions close the window: the processor driving its own address lines, its hit-modified output being active, the stop-clock state, reset, and the clock right after an accepted strobe.

When a strobe is accepted, the block registers the cache-line-aligned address and raises a one-cycle inquire-valid pulse toward the tag compare logic. The tag compare, the cache arrays, writeback sequencing and arbitration live elsewhere. They appear here only through the status inputs they drive.

Two release corner cases are decided explicitly. A strobe that arrives together with back-off in the clock where address-hold drops is refused. A strobe in the clock where the bus-hold request drops still counts, but a strobe one clock later does not.

Top module: `sqs_inquire_qualifier`

## Requirements
- R1: With address-hold asserted, a strobe at the first and second rising edges of address-hold is rejected. From the third consecutive edge onward it is accepted.
- R2: With back-off asserted, the strobe is likewise rejected at the first two consecutive edges of back-off and accepted from the third.
- R3: With hold-acknowledge asserted, a strobe at its first edge is rejected and a strobe from its second consecutive edge is accepted.
- R4: A strobe is rejected in any clock where the processor drives the address lines or asserts hit-modified.
- R5: A strobe in the clock right after an accepted strobe is rejected, so inquire-valid is never high two cycles in a row.
- R6: No strobe is accepted while stop-clock is asserted or while reset (active-low, asynchronous) is low.
- R7: The eligibility of a strobe depends on which window is open:
  - When only the back-off or hold-acknowledge window is open, a strobe is accepted only if no bus cycle is completing, or if init or probe-ready is asserted.
  - An open address-hold window accepts a strobe even while a bus cycle is completing.
- R8: A strobe is rejected in the clock where address-hold drops (high at the previous edge, low now) while back-off is high.
- R9: A strobe in the clock where the bus-hold request is first seen low is accepted if the hold-acknowledge window is open. A strobe one clock later is rejected. Two clocks later, sampling resumes normally.
- R10: On acceptance, inquire-valid is high for exactly the one cycle after the accepting edge. The line address output then carries the strobe-time address with its low log2(LINE_BYTES) bits cleared and holds it until the next acceptance.
- R11: With none of address-hold, back-off and hold-acknowledge asserted, every strobe is rejected.
- R12: While in reset, inquire-valid and the line address output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hold_i | input | 1 | Address-hold request from system logic |
| backoff_i | input | 1 | Back-off request from system logic |
| hold_req_i | input | 1 | Bus-hold request from system logic |
| hold_ack_i | input | 1 | Hold-acknowledge as driven by the processor |
| inq_strobe_i | input | 1 | External inquire address strobe |
| inq_addr_i | input | ADDR_W | Physical address driven with the strobe |
| drv_addr_i | input | 1 | Processor is driving the upper address lines |
| hit_mod_i | input | 1 | Processor hit-modified output is asserted |
| stop_clk_i | input | 1 | Core is in the stop-clock state |
| bus_busy_i | input | 1 | An in-progress bus cycle is completing |
| init_i | input | 1 | Init is asserted |
| probe_rdy_i | input | 1 | Probe-ready is asserted |
| inq_valid_o | output | 1 | One-cycle inquire-accepted pulse |
| inq_line_addr_o | output | ADDR_W | Latched cache-line-aligned inquire address |

## Verification
The bench builds the block with ADDR_W=32, LINE_BYTES=32, address-hold and back-off delays of 2 and a hold-acknowledge delay of 1. These are the smallest delays that still separate the two window types. With them, every edge of each opening window can be checked directly: rejected, rejected, then accepted. A 32-byte line makes the five cleared offset bits visible against a strobe address with all low bits set. With a one-clock hold-acknowledge delay, the same-clock and next-clock bus-hold release cases fall on adjacent edges inside one open window.

// File: rtl/sqs_pkg.sv
`timescale 1ns/1ps
package sqs_pkg;

    // Index of each bus-takeover source in the window vectors.
    typedef enum int {
        SRC_AHOLD = 0,
        SRC_BOFF  = 1,
        SRC_HLDA  = 2
    } hold_src_e;

    localparam int NSRC = 3;

    // Per-clock qualification terms computed by the top level.
    typedef struct packed {
        logic quiet;        // no bus cycle completing, or init/probe-ready
        logic eligible;     // some open window admits the strobe
        logic blocked;      // a blocking condition is present
        logic drop_reject;  // address-hold drop with back-off high
        logic late_reject;  // clock after bus-hold release
        logic accept;       // final decision
    } qual_terms_t;

endpackage

// File: rtl/sqs_hold_timer.sv
`timescale 1ns/1ps
// Counts consecutive edges on which a takeover source is high.
// The window opens once DLY edges have already been seen.
module sqs_hold_timer #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    output logic open_o,
    output logic drop_o
);
    localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1);
    localparam logic [CW-1:0] LIM = CW'(DLY);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          was;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.was = src_i;
        if (!src_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIM) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = src_i && (st_q.cnt == LIM);
    assign drop_o = st_q.was && !src_i;

endmodule

// File: rtl/sqs_release_guard.sv
`timescale 1ns/1ps
// Keeps two edges of bus-hold request history and flags the
// clock that follows its release.
module sqs_release_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req_i,
    output logic late_o
);
    typedef struct packed {
        logic h1;   // value at previous edge
        logic h2;   // value two edges back
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d.h1 = hold_req_i;
        hist_d.h2 = hist_q.h1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign late_o = hist_q.h2 && !hist_q.h1;

endmodule

// File: rtl/sqs_inquire_qualifier.sv
`timescale 1ns/1ps
module sqs_inquire_qualifier
    import sqs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int AHOLD_DLY  = 2,
    parameter int BOFF_DLY   = 2,
    parameter int HLDA_DLY   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_hold_i,
    input  logic              backoff_i,
    input  logic              hold_req_i,
    input  logic              hold_ack_i,
    input  logic              inq_strobe_i,
    input  logic [ADDR_W-1:0] inq_addr_i,
    input  logic              drv_addr_i,
    input  logic              hit_mod_i,
    input  logic              stop_clk_i,
    input  logic              bus_busy_i,
    input  logic              init_i,
    input  logic              probe_rdy_i,
    output logic              inq_valid_o,
    output logic [ADDR_W-1:0] inq_line_addr_o
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << OFS_W;

    function automatic int src_delay(input int idx);
        case (idx)
            SRC_AHOLD: return AHOLD_DLY;
            SRC_BOFF:  return BOFF_DLY;
            default:   return HLDA_DLY;
        endcase
    endfunction

    typedef struct packed {
        logic              acc;
        logic [ADDR_W-1:0] line;
    } top_st_t;

    top_st_t     st_d, st_q;
    qual_terms_t qt;

    logic [NSRC-1:0] src_vec;
    logic [NSRC-1:0] open_vec;
    logic [NSRC-1:0] drop_vec;
    logic            late_rel;

    assign src_vec[SRC_AHOLD] = addr_hold_i;
    assign src_vec[SRC_BOFF]  = backoff_i;
    assign src_vec[SRC_HLDA]  = hold_ack_i;

    // One window timer per takeover source, each with its own delay.
    for (genvar g = 0; g < NSRC; g++) begin : g_win
        sqs_hold_timer #(
            .DLY (src_delay(g))
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_vec[g]),
            .open_o (open_vec[g]),
            .drop_o (drop_vec[g])
        );
    end

    sqs_release_guard u_rel (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req_i (hold_req_i),
        .late_o     (late_rel)
    );

    always_comb begin
        qt.quiet       = !bus_busy_i || init_i || probe_rdy_i;
        qt.eligible    = open_vec[SRC_AHOLD]
                       || ((open_vec[SRC_BOFF] || open_vec[SRC_HLDA]) && qt.quiet);
        qt.blocked     = drv_addr_i || hit_mod_i || stop_clk_i || st_q.acc;
        qt.drop_reject = drop_vec[SRC_AHOLD] && backoff_i;
        qt.late_reject = late_rel;
        qt.accept      = inq_strobe_i && qt.eligible && !qt.blocked
                       && !qt.drop_reject && !qt.late_reject;

        st_d     = st_q;
        st_d.acc = qt.accept;
        if (qt.accept) begin
            st_d.line = inq_addr_i & LINE_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inq_valid_o     = st_q.acc;
    assign inq_line_addr_o = st_q.line;

endmodule

// File: rtl/sqs_inquire_qualifier_chk.sv
`timescale 1ns/1ps
module sqs_inquire_qualifier_chk #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_hold_i,
    input logic              backoff_i,
    input logic              hold_ack_i,
    input logic              inq_strobe_i,
    input logic [ADDR_W-1:0] inq_addr_i,
    input logic              drv_addr_i,
    input logic              hit_mod_i,
    input logic              stop_clk_i,
    input logic              inq_valid_o,
    input logic [ADDR_W-1:0] inq_line_addr_o
);
    localparam logic [ADDR_W-1:0] LMASK = {ADDR_W{1'b1}} << OFS_W;

    // R1
    ahold_first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_hold_i) && !backoff_i && !hold_ack_i) |=> !inq_valid_o);

    // R3
    hlda_first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_ack_i) && !addr_hold_i && !backoff_i) |=> !inq_valid_o);

    // R4
    self_drive_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_addr_i || hit_mod_i) |=> !inq_valid_o);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inq_valid_o |=> !inq_valid_o);

    // R6
    stop_clk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clk_i |=> !inq_valid_o);

    // R8
    ahold_drop_boff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(addr_hold_i) && backoff_i && inq_strobe_i) |=> !inq_valid_o);

    // R10
    line_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inq_valid_o |-> (inq_line_addr_o == ($past(inq_addr_i) & LMASK)));

    // R11
    no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_hold_i && !backoff_i && !hold_ack_i) |=> !inq_valid_o);

    // R10
    strobe_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inq_strobe_i |=> !inq_valid_o);

endmodule

bind sqs_inquire_qualifier sqs_inquire_qualifier_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_hold_i     (addr_hold_i),
    .backoff_i       (backoff_i),
    .hold_ack_i      (hold_ack_i),
    .inq_strobe_i    (inq_strobe_i),
    .inq_addr_i      (inq_addr_i),
    .drv_addr_i      (drv_addr_i),
    .hit_mod_i       (hit_mod_i),
    .stop_clk_i      (stop_clk_i),
    .inq_valid_o     (inq_valid_o),
    .inq_line_addr_o (inq_line_addr_o)
);

// File: tb/tb_sqs_inquire_qualifier.sv
`timescale 1ns/1ps
module tb_sqs_inquire_qualifier;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_hold = 0, backoff = 0, hold_req = 0, hold_ack = 0;
    logic          strobe = 0, drv_addr = 0, hit_mod = 0, stop_clk = 0;
    logic          bus_busy = 0, init = 0, probe_rdy = 0;
    logic [AW-1:0] addr = '0;
    logic          valid;
    logic [AW-1:0] line;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    sqs_inquire_qualifier #(
        .ADDR_W(AW), .LINE_BYTES(32), .AHOLD_DLY(2), .BOFF_DLY(2), .HLDA_DLY(1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .addr_hold_i(addr_hold), .backoff_i(backoff),
        .hold_req_i(hold_req), .hold_ack_i(hold_ack), .inq_strobe_i(strobe),
        .inq_addr_i(addr), .drv_addr_i(drv_addr), .hit_mod_i(hit_mod),
        .stop_clk_i(stop_clk), .bus_busy_i(bus_busy), .init_i(init),
        .probe_rdy_i(probe_rdy), .inq_valid_o(valid), .inq_line_addr_o(line)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_valid(input logic exp, input string tag);
        checks++;
        if (valid !== exp) begin
            failures++;
            $display("FAIL %s valid got=%0b exp=%0b", tag, valid, exp);
        end
    endtask

    task automatic chk_line(input logic [AW-1:0] exp, input string tag);
        checks++;
        if (line !== exp) begin
            failures++;
            $display("FAIL %s line got=%h exp=%h", tag, line, exp);
        end
    endtask

    task automatic idle();
        addr_hold = 0; backoff = 0; hold_req = 0; hold_ack = 0;
        strobe = 0; drv_addr = 0; hit_mod = 0; stop_clk = 0;
        bus_busy = 0; init = 0; probe_rdy = 0;
        repeat (3) tick();
    endtask

    task automatic t_reset();
        addr_hold = 1; strobe = 1; addr = 32'hFFFF_FFFF;
        repeat (4) tick();
        chk_valid(0, "R12 reset valid");
        chk_line('0, "R12 reset line");
        chk_valid(0, "R6 strobe during reset");
        rst_n = 1;
        idle();
    endtask

    task automatic t_ahold();
        addr_hold = 1; bus_busy = 1; strobe = 1; addr = 32'h1234_567F;
        tick(); chk_valid(0, "R1 ahold edge 1");
        tick(); chk_valid(0, "R1 ahold edge 2");
        tick(); chk_valid(1, "R1 ahold edge 3 (R7 busy ok)");
        chk_line(32'h1234_5660, "R10 line aligned");
        addr = 32'hABCD_EF1F;
        tick(); chk_valid(0, "R5 clock after accept");
        chk_line(32'h1234_5660, "R10 line held");
        tick(); chk_valid(1, "R5 accept resumes");
        chk_line(32'hABCD_EF00, "R10 new line");
        strobe = 0;
        tick(); chk_valid(0, "R10 single pulse");
        idle();
    endtask

    task automatic t_boff();
        backoff = 1; strobe = 1; addr = 32'h0000_1040;
        tick(); chk_valid(0, "R2 boff edge 1");
        tick(); chk_valid(0, "R2 boff edge 2");
        tick(); chk_valid(1, "R2 boff edge 3");
        strobe = 0; tick();
        bus_busy = 1; strobe = 1;
        tick(); chk_valid(0, "R7 boff busy rejected");
        init = 1;
        tick(); chk_valid(1, "R7 boff busy with init");
        init = 0; strobe = 0; tick();
        probe_rdy = 1; strobe = 1;
        tick(); chk_valid(1, "R7 boff busy with probe-ready");
        idle();
    endtask

    task automatic t_hlda();
        hold_req = 1; hold_ack = 1; strobe = 1; addr = 32'h0000_2000;
        tick(); chk_valid(0, "R3 hlda edge 1");
        tick(); chk_valid(1, "R3 hlda edge 2");
        strobe = 0; tick();
        bus_busy = 1; strobe = 1;
        tick(); chk_valid(0, "R7 hlda busy rejected");
        idle();
    endtask

    task automatic t_block();
        addr_hold = 1; repeat (3) tick();
        strobe = 1; drv_addr = 1;
        tick(); chk_valid(0, "R4 drv addr blocks");
        drv_addr = 0; hit_mod = 1;
        tick(); chk_valid(0, "R4 hit-modified blocks");
        hit_mod = 0; stop_clk = 1;
        tick(); chk_valid(0, "R6 stop-clock blocks");
        stop_clk = 0;
        tick(); chk_valid(1, "R4 unblocked accept");
        strobe = 0; tick();
        strobe = 1; rst_n = 0;
        #1; chk_valid(0, "R6 async reset clears");
        tick(); chk_valid(0, "R6 strobe in reset");
        rst_n = 1;
        idle();
    endtask

    task automatic t_ahold_release();
        addr_hold = 1; backoff = 1; repeat (3) tick();
        addr_hold = 0; strobe = 1;
        tick(); chk_valid(0, "R8 ahold drop with boff");
        tick(); chk_valid(1, "R8 boff alone accepts next");
        idle();
    endtask

    task automatic t_hold_release();
        hold_req = 1; hold_ack = 1; repeat (3) tick();
        hold_req = 0; strobe = 1;
        tick(); chk_valid(1, "R9 same-clock release accepted");
        idle();
        hold_req = 1; hold_ack = 1; repeat (3) tick();
        hold_req = 0;
        tick();
        strobe = 1;
        tick(); chk_valid(0, "R9 next-clock release rejected");
        tick(); chk_valid(1, "R9 two clocks later accepted");
        idle();
    endtask

    task automatic t_none();
        strobe = 1;
        tick(); chk_valid(0, "R11 no window 1");
        tick(); chk_valid(0, "R11 no window 2");
        tick(); chk_valid(0, "R11 no window 3");
        idle();
    endtask

    initial begin
        t_reset();
        t_ahold();
        t_boff();
        t_hlda();
        t_block();
        t_ahold_release();
        t_hold_release();
        t_none();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired before completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule